// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a down-counting interval timer with an automatic reload. A count source selector picks one of four single-cycle enable pulses. The choices are the base clock, the base clock divided by a fixed ratio, a programmable even-ratio prescaler, and an already-synchronised slow external strobe. While the run bit is high, each selected pulse (a tick) decrements the counter. A tick that finds the counter at zero is an underflow. An underflow copies the reload register into the counter and raises a one-cycle interrupt request. A setting of n therefore gives one interrupt every n+1 ticks.

Software reaches the block through a single write port and a counter read port. A write made while the timer is stopped loads both the reload register and the counter. A write made while it runs loads only the reload register, and the counter picks up that value at its next underflow. Every source is an enable in the one clock domain, so no derived clock is ever produced.

Top module: `reload_down_timer`

## Requirements
- R1: After reset the counter reads 0, the interrupt request is low and the reload register holds 0, so a timer started without any write underflows on every tick.
- R2: While the run bit is 1, each tick with the counter above zero lowers the counter by exactly one; the read port always shows the present counter value.
- R3: A tick that arrives while the counter is 0 loads the reload value into the counter, so a reload value of n yields one underflow every n+1 ticks.
- R4: A write while the run bit is 0 sets both the counter and the reload register to the written value on the next clock edge.
- R5: A write while the run bit is 1 changes only the reload register; the counter keeps counting and takes the new value at its next underflow.
- R6: The interrupt request is a registered pulse, high for the one clock that follows each underflowing tick and low otherwise.
- R7: While the run bit is 0, ticks are ignored and the counter holds its value except when written.
- R8: Source select 2'b00 gives a tick on every clock.
- R9: Source select 2'b01 gives one tick every 8 clocks from a divider that runs freely from reset.
- R10: Source select 2'b10 uses the 4-bit prescale field p: p=0 gives a tick on every clock, and p=1..15 gives one tick every 2p clocks.
- R11: Source select 2'b11 gives a tick in each cycle in which the slow strobe input is high.
- R12: When a write and an underflow fall in the same cycle while running, the counter takes the written value, not the old reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startBit | input | 1 | Run control: 1 counts, 0 holds |
| srcSel | input | 2 | Count source select |
| preDiv | input | 4 | Prescale field p for source 2'b10 |
| slowStrobe | input | 1 | Synchronised slow external count enable |
| wrEn | input | 1 | Write strobe for the timer register |
| wrData | input | 16 | Value written to the reload register and, when stopped, to the counter |
| count | output | 16 | Present counter value |
| irq | output | 1 | One-clock interrupt request per underflow |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 4-bit prescale field and a fixed divide-by-8 source. With the prescale field at 15, the slowest programmable tick period is 30 clocks, so reload values below about 20 still produce many underflows within a few thousand cycles. Small random reload values keep underflows and the write-versus-underflow collision frequent. The behavioural model runs its own divider and prescale counters from reset, so the phase of every source is predicted without looking inside the design.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

  // Strobes issued by the control to the datapath for one clock.
  typedef struct packed {
    logic dec;      // decrement counter by one
    logic reload;   // copy reload register into counter
    logic loadCnt;  // load written value into counter
    logic loadRel;  // load written value into reload register
    logic irqSet;   // underflow happened this cycle
  } ctrlStrobe_t;

  localparam logic [1:0] SRC_BASE    = 2'b00;
  localparam logic [1:0] SRC_FIXED   = 2'b01;
  localparam logic [1:0] SRC_PRESCL  = 2'b10;
  localparam logic [1:0] SRC_SLOW    = 2'b11;

endpackage

// File: rtl/rdt_tick_gen.sv
module rdt_tick_gen #(
  parameter int DIV_W     = 4,
  parameter int FIXED_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic [DIV_W-1:0] preDiv,
  input  logic             slowStrobe,
  output logic             srcTick
);
  import rdt_pkg::*;

  localparam int PRE_W = DIV_W + 1;

  logic fixPulse;
  logic prePulse;

  // Fixed-ratio divider; degenerates to a pass-through at ratio 1.
  generate
    if (FIXED_DIV > 1) begin : g_fixDiv
      localparam int FIX_W = $clog2(FIXED_DIV);
      logic [FIX_W-1:0] fixCnt;
      assign fixPulse = (fixCnt == FIX_W'(FIXED_DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         fixCnt <= '0;
        else if (fixPulse) fixCnt <= '0;
        else               fixCnt <= fixCnt + 1'b1;
      end
    end else begin : g_fixPass
      assign fixPulse = 1'b1;
    end
  endgenerate

  // Even-ratio prescaler: period 2p clocks, or every clock when p is zero.
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;

  assign preLimit = {preDiv, 1'b0} - 1'b1;
  assign prePulse = (preDiv == '0) || (preCnt >= preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preCnt <= '0;
    else if (prePulse) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    unique case (srcSel)
      SRC_BASE:   srcTick = 1'b1;
      SRC_FIXED:  srcTick = fixPulse;
      SRC_PRESCL: srcTick = prePulse;
      default:    srcTick = slowStrobe;
    endcase
  end

endmodule

// File: rtl/rdt_ctrl.sv
module rdt_ctrl (
  input  logic                 startBit,
  input  logic                 srcTick,
  input  logic                 wrEn,
  input  logic                 cntZero,
  output rdt_pkg::ctrlStrobe_t strb
);

  logic tick;
  logic underflow;

  assign tick      = srcTick && startBit;
  assign underflow = tick && cntZero;

  always_comb begin
    strb         = '0;
    strb.loadRel = wrEn;
    // Stopped write, or a write landing on an underflow, goes to the counter.
    strb.loadCnt = wrEn && (!startBit || underflow);
    strb.reload  = underflow && !wrEn;
    strb.dec     = tick && !underflow;
    strb.irqSet  = underflow;
  end

endmodule

// File: rtl/rdt_datapath.sv
module rdt_datapath #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rdt_pkg::ctrlStrobe_t strb,
  input  logic [CNT_W-1:0]     wrData,
  output logic [CNT_W-1:0]     count,
  output logic                 cntZero,
  output logic                 irq
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] relQ;
  logic             irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= wrData;
    end else if (strb.reload) begin
      cntQ <= relQ;
    end else if (strb.dec) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             relQ <= '0;
    else if (strb.loadRel) relQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strb.irqSet;
  end

  assign count   = cntQ;
  assign cntZero = (cntQ == '0);
  assign irq     = irqQ;

endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer #(
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 4,
  parameter int FIXED_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBit,
  input  logic [1:0]       srcSel,
  input  logic [DIV_W-1:0] preDiv,
  input  logic             slowStrobe,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             irq
);

  logic                 srcTick;
  logic                 cntZero;
  rdt_pkg::ctrlStrobe_t strb;

  rdt_tick_gen #(.DIV_W(DIV_W), .FIXED_DIV(FIXED_DIV)) u_tick (
    .clk       (clk),
    .rstN      (rstN),
    .srcSel    (srcSel),
    .preDiv    (preDiv),
    .slowStrobe(slowStrobe),
    .srcTick   (srcTick)
  );

  rdt_ctrl u_ctrl (
    .startBit(startBit),
    .srcTick (srcTick),
    .wrEn    (wrEn),
    .cntZero (cntZero),
    .strb    (strb)
  );

  rdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .count  (count),
    .cntZero(cntZero),
    .irq    (irq)
  );

endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startBit,
  input logic             wrEn,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] count,
  input logic             irq
);

  // R4: stopped write lands in the counter on the next edge
  a_r4_stopped_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !startBit) |=> (count == $past(wrData)));

  // R7: stopped and unwritten counter holds
  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!startBit && !wrEn) |=> $stable(count));

  // R2: running without a write, a nonzero counter either holds or steps down by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && !wrEn && count != '0) |=>
      ((count == $past(count)) || (count == $past(count) - 1'b1)));

  // R6: an interrupt only follows a running cycle with the counter at zero
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(startBit) && ($past(count) == '0)));

  // R3: leaving zero while running without a write is never a decrement wrap
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (startBit && !wrEn && count == '0 && !irq) |=> (count == '0 || irq));

endmodule

bind reload_down_timer rdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startBit(startBit),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .count   (count),
  .irq     (irq)
);

// File: tb/reload_down_timer_test.sv
module reload_down_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startBit = 1'b0;
  logic [1:0]       srcSel = 2'b00;
  logic [3:0]       preDiv = 4'd0;
  logic             slowStrobe = 1'b0;
  logic             wrEn = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] count;
  logic             irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_down_timer uut (
    .clk(clk), .rstN(rstN), .startBit(startBit), .srcSel(srcSel),
    .preDiv(preDiv), .slowStrobe(slowStrobe), .wrEn(wrEn),
    .wrData(wrData), .count(count), .irq(irq)
  );

  // Behavioural reference model
  int mCnt, mRel, mDiv8, mPre;
  bit mIrq;

  always @(posedge clk) begin
    bit src, tk, uf;
    int lim;
    if (!rstN) begin
      mCnt = 0; mRel = 0; mIrq = 0; mDiv8 = 0; mPre = 0;
    end else begin
      lim = 2 * preDiv - 1;
      case (srcSel)
        2'b00: src = 1;
        2'b01: src = (mDiv8 == 7);
        2'b10: src = (preDiv == 0) || (mPre >= lim);
        default: src = slowStrobe;
      endcase
      mDiv8 = (mDiv8 + 1) % 8;
      mPre  = ((preDiv == 0) || (mPre >= lim)) ? 0 : mPre + 1;
      tk = src && startBit;
      uf = tk && (mCnt == 0);
      mIrq = uf;
      if (wrEn) begin
        mRel = wrData;
        if (!startBit || uf) mCnt = wrData;
        else if (tk) mCnt = mCnt - 1;
      end else if (uf) mCnt = mRel;
      else if (tk) mCnt = mCnt - 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Advance one clock, then compare against the model away from the edge.
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    check("R2 count", int'(count), mCnt);
    check("R6 irq", int'(irq), int'(mIrq));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset count", int'(count), 0);
    check("R1 reset irq", int'(irq), 0);
    rstN = 1'b1;
    cycle();

    // R1 / R8: reload 0 and base source -> irq every clock
    startBit = 1; srcSel = 2'b00;
    cycle(); cycle();
    check("R1 irq every tick with zero reload", int'(irq), 1);
    for (int i = 0; i < 6; i++) cycle();

    // R4: stopped write
    startBit = 0; cycle();
    wrEn = 1; wrData = 16'd5; cycle(); wrEn = 0;
    check("R4 stopped write to counter", int'(count), 5);

    // R7: ticks ignored while stopped
    srcSel = 2'b11; slowStrobe = 1;
    for (int i = 0; i < 4; i++) cycle();
    check("R7 hold while stopped", int'(count), 5);
    slowStrobe = 0;

    // R2 / R3 / R8: run from 5 on base clock, period 6
    srcSel = 2'b00; startBit = 1;
    for (int i = 0; i < 5; i++) cycle();
    check("R2 reached zero", int'(count), 0);
    cycle();
    check("R3 reload value", int'(count), 5);
    check("R6 irq after underflow", int'(irq), 1);
    cycle();
    check("R6 irq one clock", int'(irq), 0);

    // R5: running write only touches reload
    wrEn = 1; wrData = 16'd9; cycle(); wrEn = 0;
    check("R5 counter not loaded while running", int'(count), 3);
    for (int i = 0; i < 4; i++) cycle();
    check("R5 new value at next reload", int'(count), 9);

    // R12: write colliding with an underflow
    startBit = 0; wrEn = 1; wrData = 16'd0; cycle();
    startBit = 1; wrData = 16'd12; cycle(); wrEn = 0;
    check("R12 written value wins at underflow", int'(count), 12);
    check("R12 underflow still flagged", int'(irq), 1);

    // R9: fixed divide-by-8
    startBit = 0; wrEn = 1; wrData = 16'd3; cycle(); wrEn = 0;
    srcSel = 2'b01; startBit = 1;
    for (int i = 0; i < 80; i++) cycle();

    // R10: prescaler settings
    for (int p = 0; p < 16; p += 5) begin
      preDiv = 4'(p); srcSel = 2'b10;
      for (int i = 0; i < 150; i++) cycle();
    end
    preDiv = 4'd15;
    for (int i = 0; i < 200; i++) cycle();

    // R11: slow strobe
    srcSel = 2'b11;
    for (int i = 0; i < 200; i++) begin
      slowStrobe = ($urandom % 4) == 0;
      cycle();
    end
    slowStrobe = 0;

    // Mixed random traffic across all requirements
    for (int i = 0; i < 4000; i++) begin
      startBit   = ($urandom % 10) != 0;
      wrEn       = ($urandom % 12) == 0;
      wrData     = CNT_W'($urandom % 20);
      slowStrobe = $urandom % 2;
      if ($urandom % 50 == 0) srcSel = 2'($urandom);
      if ($urandom % 100 == 0) preDiv = 4'($urandom);
      cycle();
    end
    wrEn = 0;
    finish_run();
  end

endmodule